// File: doc/BRIEF.md
# CAN Receive Acceptance Filter Bank

This block decides which receive message buffers take an incoming CAN frame. Each of sixteen buffers holds an acceptance code identifier, a format flag (standard or extended), a valid bit and a two-bit filter-mode select. Two shared acceptance masks can be chosen per buffer. A configuration write port loads codes, format flags, selects, valid bits and the masks, one field per cycle. A frame identifier presented with its format flag and a lookup strobe is compared against every buffer in parallel. One clock later the block shows the set of matching buffers, the index of the lowest-numbered match and a hit flag. The result holds until the next strobe.

The result stage is a small state machine with three states. RS_IDLE is the state after reset, before any lookup. RS_HIT means the last lookup matched at least one buffer. RS_MISS means the last lookup matched none. On every strobe, each state moves to RS_HIT when some buffer matches (transition "lookup hit") and to RS_MISS when none matches (transition "lookup miss"). Without a strobe, each state holds. The hit flag is high only in RS_HIT.

Top module: `acc_filter_bank`

## Requirements
- R1: After reset, res_vec, res_idx and res_hit are 0, and every buffer is invalid, with code 0, standard format, select 00 and both masks 0.
- R2: A standard-format buffer compares only identifier bits 28 down to 18. Bits 17 down to 0 of the received identifier have no effect.
- R3: An extended-format buffer compares all 29 identifier bits, 28 down to 0.
- R4: Select 00 needs an exact match on every compared bit. Select 01 accepts any identifier whose format flag equals the buffer's format flag.
- R5: Select 10 applies shared mask 0 and select 11 applies shared mask 1. A mask bit of 1 makes that identifier bit a don't-care, and a mask bit of 0 requires equality.
- R6: Mask writes use cfg_idx[0] to choose the mask. Kind 3 takes cfg_data[7:0] as identifier bits 28..21 and cfg_data[15:8] as bits 20..13. Kind 4 takes cfg_data[7:0] as bits 12..5 and cfg_data[15:11] as bits 4..0. In each byte, the lower data bit maps to the lower identifier bit.
- R7: A buffer whose valid bit is 0 never matches. Kind 2 writes the valid bit from cfg_data[0].
- R8: Kind 1 writes the select from cfg_data[1:0], but only while the target buffer is invalid. On a valid buffer the write is ignored.
- R9: A buffer matches only when its format flag equals lk_ext. Kind 0 writes the code from cfg_data[28:0] and the format flag from cfg_data[29] (1 = extended).
- R10: Bit i of res_vec is set for every matching buffer i. When several buffers match, res_idx names the lowest-numbered one.
- R11: res_vec, res_idx and res_hit change on the clock edge that samples lk_stb high and hold their values until the next strobe, whatever configuration writes occur in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_kind | input | 3 | Write kind: 0 code, 1 select, 2 valid, 3 mask upper half, 4 mask lower half |
| cfg_idx | input | 4 | Target buffer; bit 0 selects the mask for mask writes |
| cfg_data | input | 30 | Write data |
| lk_stb | input | 1 | Lookup strobe |
| lk_id | input | 29 | Received identifier (standard frames use bits 28..18) |
| lk_ext | input | 1 | Received frame is extended |
| res_vec | output | 16 | Per-buffer match vector |
| res_idx | output | 4 | Lowest matching buffer index |
| res_hit | output | 1 | At least one buffer matched |

## Verification
The bound checker enforces four rules on every cycle:
- The result never reports a buffer that was invalid when the strobe was sampled.
- No match sits below the reported winner, and a raised hit flag points at a set vector bit.
- The result holds between strobes.
- A select write aimed at a valid buffer leaves all selects unchanged.

Only the directed scenarios can show that a match is correct. These cover the compared width per format, each filter mode, the byte placement of mask writes, the rejection of a format mismatch and priority among several matching buffers.

// File: rtl/acc_filter_pkg.sv
package acc_filter_pkg;
    localparam int ID_W  = 29;
    localparam int STD_W = 11;

    typedef enum logic [2:0] {
        CFG_CODE    = 3'd0,
        CFG_SEL     = 3'd1,
        CFG_VALID   = 3'd2,
        CFG_MASK_HI = 3'd3,
        CFG_MASK_LO = 3'd4
    } cfg_kind_e;

    typedef enum logic [1:0] {
        SEL_EXACT = 2'b00,
        SEL_ANY   = 2'b01,
        SEL_MASK0 = 2'b10,
        SEL_MASK1 = 2'b11
    } sel_e;

    typedef enum logic [1:0] {
        RS_IDLE = 2'd0,
        RS_HIT  = 2'd1,
        RS_MISS = 2'd2
    } res_state_e;
endpackage

// File: rtl/acc_cfg_regs.sv
module acc_cfg_regs
    import acc_filter_pkg::*;
#(
    parameter int NBUF  = 16,
    parameter int IDX_W = $clog2(NBUF)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [2:0]           cfg_kind,
    input  logic [IDX_W-1:0]     cfg_idx,
    input  logic [29:0]          cfg_data,
    output logic [NBUF*ID_W-1:0] code_flat,
    output logic [NBUF-1:0]      ext_vec,
    output logic [NBUF-1:0]      valid_vec,
    output logic [2*NBUF-1:0]    sel_flat,
    output logic [ID_W-1:0]      mask0,
    output logic [ID_W-1:0]      mask1
);
    cfg_kind_e kind;
    assign kind = cfg_kind_e'(cfg_kind);

    for (genvar b = 0; b < NBUF; b++) begin : g_buf
        logic [ID_W-1:0] code_q;
        logic            ext_q;
        logic            valid_q;
        logic [1:0]      sel_q;
        logic            tgt;

        assign tgt = cfg_we && (cfg_idx == IDX_W'(b));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                code_q  <= '0;
                ext_q   <= 1'b0;
                valid_q <= 1'b0;
                sel_q   <= SEL_EXACT;
            end else if (tgt) begin
                case (kind)
                    CFG_CODE: begin
                        code_q <= cfg_data[ID_W-1:0];
                        ext_q  <= cfg_data[29];
                    end
                    CFG_SEL: begin
                        if (!valid_q) sel_q <= cfg_data[1:0];
                    end
                    CFG_VALID: valid_q <= cfg_data[0];
                    default: ;
                endcase
            end
        end

        assign code_flat[b*ID_W +: ID_W] = code_q;
        assign ext_vec[b]                = ext_q;
        assign valid_vec[b]              = valid_q;
        assign sel_flat[2*b +: 2]        = sel_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask0 <= '0;
            mask1 <= '0;
        end else if (cfg_we) begin
            if (kind == CFG_MASK_HI) begin
                if (cfg_idx[0]) mask1[28:13] <= {cfg_data[7:0], cfg_data[15:8]};
                else            mask0[28:13] <= {cfg_data[7:0], cfg_data[15:8]};
            end else if (kind == CFG_MASK_LO) begin
                if (cfg_idx[0]) mask1[12:0] <= {cfg_data[7:0], cfg_data[15:11]};
                else            mask0[12:0] <= {cfg_data[7:0], cfg_data[15:11]};
            end
        end
    end
endmodule

// File: rtl/acc_match_lane.sv
module acc_match_lane
    import acc_filter_pkg::*;
(
    input  logic [ID_W-1:0] code,
    input  logic            ext,
    input  logic            valid,
    input  logic [1:0]      sel,
    input  logic [ID_W-1:0] mask0,
    input  logic [ID_W-1:0] mask1,
    input  logic [ID_W-1:0] lk_id,
    input  logic            lk_ext,
    output logic            hit
);
    localparam logic [ID_W-1:0] STD_ACT = {{STD_W{1'b1}}, {(ID_W-STD_W){1'b0}}};

    logic [ID_W-1:0] act;
    logic [ID_W-1:0] dont_care;
    logic [ID_W-1:0] diff;

    always_comb begin
        act = ext ? '1 : STD_ACT;
        unique case (sel_e'(sel))
            SEL_EXACT: dont_care = '0;
            SEL_ANY:   dont_care = '1;
            SEL_MASK0: dont_care = mask0;
            SEL_MASK1: dont_care = mask1;
            default:   dont_care = '0;
        endcase
        diff = (code ^ lk_id) & act & ~dont_care;
        hit  = valid && (ext == lk_ext) && (diff == '0);
    end
endmodule

// File: rtl/acc_prio_enc.sv
module acc_prio_enc #(
    parameter int NBUF  = 16,
    parameter int IDX_W = $clog2(NBUF)
) (
    input  logic [NBUF-1:0]  vec,
    output logic [IDX_W-1:0] idx,
    output logic             any
);
    always_comb begin
        idx = '0;
        any = |vec;
        for (int i = NBUF - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/acc_filter_bank.sv
module acc_filter_bank
    import acc_filter_pkg::*;
#(
    parameter int NBUF  = 16,
    parameter int IDX_W = $clog2(NBUF)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_kind,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic [29:0]      cfg_data,
    input  logic             lk_stb,
    input  logic [28:0]      lk_id,
    input  logic             lk_ext,
    output logic [NBUF-1:0]  res_vec,
    output logic [IDX_W-1:0] res_idx,
    output logic             res_hit
);
    logic [NBUF*ID_W-1:0] code_flat;
    logic [NBUF-1:0]      ext_vec;
    logic [NBUF-1:0]      valid_vec;
    logic [2*NBUF-1:0]    sel_flat;
    logic [ID_W-1:0]      mask0;
    logic [ID_W-1:0]      mask1;
    logic [NBUF-1:0]      lane_hit;
    logic [IDX_W-1:0]     win_idx;
    logic                 win_any;

    res_state_e state_q, state_d;
    logic [NBUF-1:0]  vec_q;
    logic [IDX_W-1:0] idx_q;

    acc_cfg_regs #(.NBUF(NBUF), .IDX_W(IDX_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_kind  (cfg_kind),
        .cfg_idx   (cfg_idx),
        .cfg_data  (cfg_data),
        .code_flat (code_flat),
        .ext_vec   (ext_vec),
        .valid_vec (valid_vec),
        .sel_flat  (sel_flat),
        .mask0     (mask0),
        .mask1     (mask1)
    );

    for (genvar b = 0; b < NBUF; b++) begin : g_lane
        acc_match_lane u_lane (
            .code   (code_flat[b*ID_W +: ID_W]),
            .ext    (ext_vec[b]),
            .valid  (valid_vec[b]),
            .sel    (sel_flat[2*b +: 2]),
            .mask0  (mask0),
            .mask1  (mask1),
            .lk_id  (lk_id),
            .lk_ext (lk_ext),
            .hit    (lane_hit[b])
        );
    end

    acc_prio_enc #(.NBUF(NBUF), .IDX_W(IDX_W)) u_prio (
        .vec (lane_hit),
        .idx (win_idx),
        .any (win_any)
    );

    // next-state decode
    always_comb begin
        unique case (state_q)
            RS_IDLE, RS_HIT, RS_MISS:
                state_d = lk_stb ? (win_any ? RS_HIT : RS_MISS) : state_q;
            default: state_d = RS_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RS_IDLE;
        else        state_q <= state_d;
    end

    // captured result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_q <= '0;
            idx_q <= '0;
        end else if (lk_stb) begin
            vec_q <= lane_hit;
            idx_q <= win_idx;
        end
    end

    // outputs
    always_comb begin
        res_vec = vec_q;
        res_idx = idx_q;
        res_hit = (state_q == RS_HIT);
    end
endmodule

// File: rtl/acc_filter_chk.sv
module acc_filter_chk #(
    parameter int NBUF  = 16,
    parameter int IDX_W = $clog2(NBUF)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [2:0]       cfg_kind,
    input logic [IDX_W-1:0] cfg_idx,
    input logic             lk_stb,
    input logic [NBUF-1:0]  res_vec,
    input logic [IDX_W-1:0] res_idx,
    input logic             res_hit,
    input logic [NBUF-1:0]  valid_vec,
    input logic [2*NBUF-1:0] sel_flat
);
    logic [NBUF-1:0] below_win;
    always_comb begin
        below_win = '0;
        for (int i = 0; i < NBUF; i++) begin
            if (IDX_W'(i) < res_idx) below_win[i] = 1'b1;
        end
    end

    // R7
    invalid_never_hits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lk_stb) |-> ((res_vec & ~$past(valid_vec)) == '0));

    // R10
    lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vec & below_win) == '0);

    // R10
    hit_points_at_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_hit |-> res_vec[res_idx]);

    // R11
    result_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(lk_stb) |-> ($stable(res_vec) && $stable(res_idx) && $stable(res_hit)));

    // R8
    sel_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_kind == 3'd1 && valid_vec[cfg_idx]) |=> $stable(sel_flat));
endmodule

bind acc_filter_bank acc_filter_chk #(.NBUF(NBUF), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_kind  (cfg_kind),
    .cfg_idx   (cfg_idx),
    .lk_stb    (lk_stb),
    .res_vec   (res_vec),
    .res_idx   (res_idx),
    .res_hit   (res_hit),
    .valid_vec (valid_vec),
    .sel_flat  (sel_flat)
);

// File: tb/sim_acc_filter_bank.sv
module sim_acc_filter_bank;
    localparam int NBUF  = 16;
    localparam int IDX_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic [2:0]       cfg_kind = '0;
    logic [IDX_W-1:0] cfg_idx = '0;
    logic [29:0]      cfg_data = '0;
    logic             lk_stb = 1'b0;
    logic [28:0]      lk_id = '0;
    logic             lk_ext = 1'b0;
    logic [NBUF-1:0]  res_vec;
    logic [IDX_W-1:0] res_idx;
    logic             res_hit;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    acc_filter_bank #(.NBUF(NBUF), .IDX_W(IDX_W)) u0 (.*);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] kind, int idx, logic [29:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_kind = kind; cfg_idx = IDX_W'(idx); cfg_data = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_buf(int idx, logic ext, logic [28:0] code, logic [1:0] sel);
        wr(3'd2, idx, 30'd0);
        wr(3'd0, idx, {ext, code});
        wr(3'd1, idx, {28'd0, sel});
        wr(3'd2, idx, 30'd1);
    endtask

    task automatic kill(int idx);
        wr(3'd2, idx, 30'd0);
    endtask

    task automatic look(string req, logic [28:0] id, logic ext, logic [NBUF-1:0] exp_vec);
        int win = 0;
        for (int i = NBUF - 1; i >= 0; i--) if (exp_vec[i]) win = i;
        @(negedge clk);
        lk_stb = 1'b1; lk_id = id; lk_ext = ext;
        @(negedge clk);
        lk_stb = 1'b0;
        check({req, " vec"}, 32'(res_vec), 32'(exp_vec));
        check({req, " idx"}, 32'(res_idx), 32'(win));
        check({req, " hit"}, 32'(res_hit), 32'(exp_vec != 0));
    endtask

    task automatic t_reset;
        check("R1 vec", 32'(res_vec), 0);
        check("R1 idx", 32'(res_idx), 0);
        check("R1 hit", 32'(res_hit), 0);
        look("R1 lookup", 29'd0, 1'b0, '0);
        look("R1 ext lookup", 29'd0, 1'b1, '0);
    endtask

    task automatic t_standard;
        set_buf(3, 1'b0, 29'h123 << 18, 2'b00);
        look("R2 low bits ignored", (29'h123 << 18) | 29'h2ABCD, 1'b0, 16'h0008);
        look("R2 bit18 compared", (29'h122 << 18), 1'b0, '0);
        kill(3);
    endtask

    task automatic t_extended;
        set_buf(5, 1'b1, 29'h1ABCDEF1, 2'b00);
        look("R3 exact", 29'h1ABCDEF1, 1'b1, 16'h0020);
        look("R3 bit0 compared", 29'h1ABCDEF0, 1'b1, '0);
        look("R9 format mismatch", 29'h1ABCDEF1, 1'b0, '0);
        kill(5);
    endtask

    task automatic t_any;
        set_buf(7, 1'b0, 29'd0, 2'b01);
        look("R4 any std", 29'h555 << 18, 1'b0, 16'h0080);
        look("R9 any ext rejected", 29'h155, 1'b1, '0);
        kill(7);
    endtask

    task automatic t_masks;
        wr(3'd4, 0, 30'h0F807);
        set_buf(9, 1'b1, 29'h0A5A5A00, 2'b10);
        look("R5 mask0 dont-care", 29'h0A5A5AFF, 1'b1, 16'h0200);
        look("R6 mask0 bit8 compared", 29'h0A5A5B00, 1'b1, '0);
        kill(9);
        wr(3'd3, 1, 30'h001FF);
        set_buf(10, 1'b1, 29'd0, 2'b11);
        look("R6 mask1 upper bytes", 29'h1FE02000, 1'b1, 16'h0400);
        look("R5 mask1 bit14 compared", 29'h00004000, 1'b1, '0);
        kill(10);
    endtask

    task automatic t_invalid;
        wr(3'd0, 2, {1'b0, 29'h7FF << 18});
        look("R7 invalid", 29'h7FF << 18, 1'b0, '0);
        wr(3'd2, 2, 30'd1);
        look("R7 valid", 29'h7FF << 18, 1'b0, 16'h0004);
        kill(2);
        look("R7 invalid again", 29'h7FF << 18, 1'b0, '0);
    endtask

    task automatic t_sel_lock;
        set_buf(4, 1'b0, 29'h0AA << 18, 2'b01);
        wr(3'd1, 4, 30'd0);
        look("R8 select locked", 29'h033 << 18, 1'b0, 16'h0010);
        kill(4);
        wr(3'd1, 4, 30'd0);
        wr(3'd2, 4, 30'd1);
        look("R8 select after invalid", 29'h033 << 18, 1'b0, '0);
        look("R8 exact now", 29'h0AA << 18, 1'b0, 16'h0010);
        kill(4);
    endtask

    task automatic t_priority;
        set_buf(1, 1'b0, 29'd0, 2'b01);
        set_buf(6, 1'b0, 29'd0, 2'b01);
        set_buf(12, 1'b0, 29'd0, 2'b01);
        look("R10 three match", 29'h3C << 18, 1'b0, 16'h1042);
        kill(1);
        look("R10 next winner", 29'h3C << 18, 1'b0, 16'h1040);
        kill(6); kill(12);
        set_buf(15, 1'b0, 29'd0, 2'b01);
        look("R10 top buffer", 29'h1 << 18, 1'b0, 16'h8000);
    endtask

    task automatic t_hold;
        @(negedge clk);
        lk_stb = 1'b1; lk_id = 29'h0; lk_ext = 1'b0;
        check("R11 before edge", 32'(res_vec), 32'h8000);
        @(negedge clk);
        lk_stb = 1'b0;
        check("R11 after edge", 32'(res_idx), 15);
        kill(15);
        repeat (3) @(negedge clk);
        check("R11 hold vec", 32'(res_vec), 32'h8000);
        check("R11 hold hit", 32'(res_hit), 1);
        look("R11 new strobe", 29'h0, 1'b0, '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_standard();
        t_extended();
        t_any();
        t_masks();
        t_invalid();
        t_sel_lock();
        t_priority();
        t_hold();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule